// File: doc/BRIEF.md
# LCD Frame-Synchronized Control Register

This block holds the 8-bit control and status word of an LCD controller. Software reaches it over a simple register bus with an address, a write enable, write data and combinational read data. The LCD timing generator supplies a one-cycle frame-start strobe. The block drives the enable, waveform-select and blanking levels that the segment driver sees, and it raises an interrupt request toward the interrupt controller. The interrupt controller answers that request with a one-cycle acknowledge.

Not every write takes effect at once. The enable and the interrupt enable act on the next clock edge. The waveform select and the blanking control act only at a frame boundary while the controller is running, so the driver never sees a change in the middle of a frame. A start-of-frame flag is set when a frame begins. Software clears it by writing a one to it, and the acknowledge also clears it. While the low-power waveform is in effect, the flag is raised on only every second frame.

Top module: `lcd_frame_ctrl_reg`

## Requirements
- R1: After reset every output is 0, and a read of the register address returns 0x00.
- R2: Bit 7 is the controller enable. A write to the register sets `drv_enable` to that bit on the next clock edge. A write of 0 switches the driver off on that edge, whatever the frame position.
- R3: Bits 5, 2 and 1 always read as 0, whatever value was written to them.
- R4: Bit 6 selects the waveform (1 = low power, 0 = default). It reads back at once. While the controller is enabled, `drv_lowpwr` takes the new value only on a frame-start edge. While it is disabled, `drv_lowpwr` follows the field on the next edge.
- R5: Bit 0 requests blanking. Both setting and clearing it follow the same frame-aligned rule as R4, and the result appears on `drv_blank`.
- R6: With the default waveform in effect, each frame strobe that arrives while the controller is enabled sets the flag at bit 4 on that edge.
- R7: Writing 1 to bit 4 clears the flag. Writing 0 to bit 4 leaves it unchanged.
- R8: An `irq_ack` pulse clears the flag.
- R9: When a flag set and a clear (a write-one or an acknowledge) fall in the same cycle, the flag ends up set.
- R10: `irq_req` is 1 exactly when the flag, bit 3 (interrupt enable) and `global_ie` are all 1.
- R11: While the low-power waveform is in effect, the flag is set on the first frame after that waveform takes effect or after the controller is enabled, then on every second frame after that. The count restarts whenever the controller is disabled or the waveform changes.
- R12: Frame strobes that arrive while the controller is disabled neither set the flag nor advance the frame count.
- R13: Writes to any address other than `REG_ADDR` change nothing, and reads from other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| frame_start | input | 1 | One-cycle frame-begin strobe from the timing generator |
| irq_ack | input | 1 | Interrupt acknowledge from the interrupt controller |
| global_ie | input | 1 | Global interrupt enable |
| drv_enable | output | 1 | Live controller enable to the driver |
| drv_lowpwr | output | 1 | Live waveform select to the driver |
| drv_blank | output | 1 | Live blanking control to the driver |
| irq_req | output | 1 | Start-of-frame interrupt request |

## Verification
Every register effect is due exactly one edge after the stimulus: a write, a frame strobe or an acknowledge sampled at edge k shows on `drv_*`, on the flag and on the read data just after edge k. `irq_req` and `bus_rdata` also depend combinationally on `global_ie` and `bus_addr` in the same cycle. The bench drives all inputs at the falling edge. It advances its reference model once for each rising edge and compares every output at the following falling edge, so each result is sampled in the cycle it becomes due.

// File: rtl/lcdr_pkg.sv
// Shared constants and types for the LCD frame-synchronized control register.
// Assumes an 8-bit register word. The bit positions are fixed because software decodes them.
package lcdr_pkg;
    localparam int DATA_W  = 8;
    localparam int EN_B    = 7;
    localparam int WAVE_B  = 6;
    localparam int FLAG_B  = 4;
    localparam int IE_B    = 3;
    localparam int BLANK_B = 0;

    // Writable control fields, as held in the register or as their next value
    typedef struct packed {
        logic en;
        logic wave;
        logic ie;
        logic blank;
    } lcdr_ctl_t;
endpackage

// File: rtl/lcdr_bus_if.sv
// Bus side of the register: address decode, the writable fields and the read mux.
// Assumes single-cycle writes and combinational reads. It also exports the next
// field values so that the frame logic can load a write that lands on a frame edge.
module lcdr_bus_if
    import lcdr_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag_i,
    output lcdr_ctl_t         ctl_q,
    output lcdr_ctl_t         ctl_nxt,
    output logic              clr_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic hit;
    logic wr;

    assign hit = (bus_addr == REG_ADDR);
    assign wr  = bus_we && hit;

    // Next field values: the write data on a hit, otherwise the held values
    always_comb begin
        if (wr) begin
            ctl_nxt.en    = bus_wdata[EN_B];
            ctl_nxt.wave  = bus_wdata[WAVE_B];
            ctl_nxt.ie    = bus_wdata[IE_B];
            ctl_nxt.blank = bus_wdata[BLANK_B];
        end else begin
            ctl_nxt = ctl_q;
        end
    end

    // Field storage, all zero after reset
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_nxt;
    end

    // A write of one to the flag position requests a clear
    assign clr_wr = wr && bus_wdata[FLAG_B];

    // Read mux; the reserved positions stay zero
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[EN_B]    = ctl_q.en;
            bus_rdata[WAVE_B]  = ctl_q.wave;
            bus_rdata[FLAG_B]  = flag_i;
            bus_rdata[IE_B]    = ctl_q.ie;
            bus_rdata[BLANK_B] = ctl_q.blank;
        end
    end
endmodule

// File: rtl/lcdr_frame_sync.sv
// Holds the waveform and blanking levels the driver sees. While enabled, these
// levels take the requested values only on a frame strobe. While disabled, they
// follow the requests on every edge. Assumes frame_start is a one-cycle pulse.
module lcdr_frame_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic frame_start,
    input  logic wave_nxt,
    input  logic blank_nxt,
    output logic frame_ok,
    output logic wave_live,
    output logic blank_live
);
    logic load;

    assign frame_ok = en_q && frame_start;
    assign load     = frame_ok || !en_q;

    // Load the live levels at a frame boundary or while the controller is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_live  <= 1'b0;
            blank_live <= 1'b0;
        end else if (load) begin
            wave_live  <= wave_nxt;
            blank_live <= blank_nxt;
        end
    end
endmodule

// File: rtl/lcdr_flag_unit.sv
// Start-of-frame flag, with decimation by two in the low-power waveform.
// The phase bit restarts on disable or on a waveform change. When a set and a
// clear fall in the same cycle, the set wins.
module lcdr_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic frame_ok,
    input  logic wave_nxt,
    input  logic wave_live,
    input  logic clr_req,
    output logic flag_q
);
    logic phase_q;
    logic eff_phase;
    logic set_ev;

    // A waveform change restarts the count, so this frame counts as the first
    assign eff_phase = (wave_nxt != wave_live) ? 1'b0 : phase_q;
    assign set_ev    = frame_ok && (!wave_nxt || !eff_phase);

    // Phase: toggles per low-power frame, zero otherwise or while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) phase_q <= 1'b0;
        else if (frame_ok)   phase_q <= wave_nxt ? !eff_phase : 1'b0;
    end

    // Flag: set has priority over a write-one or an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_ev)  flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end
endmodule

// File: rtl/lcd_frame_ctrl_reg.sv
// Top of the LCD frame-synchronized control register. Joins the bus side, the
// frame-aligned driver levels and the interrupt flag. Assumes a single clock and
// that frame_start and irq_ack are already synchronous to it.
module lcd_frame_ctrl_reg
    import lcdr_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              frame_start,
    input  logic              irq_ack,
    input  logic              global_ie,
    output logic              drv_enable,
    output logic              drv_lowpwr,
    output logic              drv_blank,
    output logic              irq_req
);
    lcdr_ctl_t ctl_q;
    lcdr_ctl_t ctl_nxt;
    logic      clr_wr;
    logic      frame_ok;
    logic      flag_q;

    lcdr_bus_if #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .flag_i    (flag_q),
        .ctl_q     (ctl_q),
        .ctl_nxt   (ctl_nxt),
        .clr_wr    (clr_wr),
        .bus_rdata (bus_rdata)
    );

    lcdr_frame_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_q        (ctl_q.en),
        .frame_start (frame_start),
        .wave_nxt    (ctl_nxt.wave),
        .blank_nxt   (ctl_nxt.blank),
        .frame_ok    (frame_ok),
        .wave_live   (drv_lowpwr),
        .blank_live  (drv_blank)
    );

    lcdr_flag_unit u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_q      (ctl_q.en),
        .frame_ok  (frame_ok),
        .wave_nxt  (ctl_nxt.wave),
        .wave_live (drv_lowpwr),
        .clr_req   (clr_wr || irq_ack),
        .flag_q    (flag_q)
    );

    assign drv_enable = ctl_q.en;
    assign irq_req    = flag_q && ctl_q.ie && global_ie;
endmodule

// File: rtl/lcdr_checker.sv
// Protocol checks for lcd_frame_ctrl_reg, attached with bind.
// Assumes the same reset and clock as the top module.
module lcdr_checker #(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              frame_start,
    input logic              irq_ack,
    input logic              global_ie,
    input logic              drv_enable,
    input logic              drv_lowpwr,
    input logic              drv_blank,
    input logic              irq_req,
    input logic              flag_q
);
    // R2
    disable_at_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR && !bus_wdata[7]) |=> !drv_enable);

    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[5] == 1'b0) && (bus_rdata[2] == 1'b0) && (bus_rdata[1] == 1'b0));

    // R4
    mid_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_enable && !frame_start) |=> ($stable(drv_lowpwr) && $stable(drv_blank)));

    // R6
    default_frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_enable && frame_start && !drv_lowpwr) |=> flag_q);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(drv_enable && frame_start)) |=> !flag_q);

    // R10
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !global_ie |-> !irq_req);

    // R12
    disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_enable && !flag_q) |=> !flag_q);
endmodule

bind lcd_frame_ctrl_reg lcdr_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_lcdr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .frame_start (frame_start),
    .irq_ack     (irq_ack),
    .global_ie   (global_ie),
    .drv_enable  (drv_enable),
    .drv_lowpwr  (drv_lowpwr),
    .drv_blank   (drv_blank),
    .irq_req     (irq_req),
    .flag_q      (flag_q)
);

// File: tb/test_lcd_frame_ctrl_reg.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared cycle by cycle against a reference model built from the requirements.
module test_lcd_frame_ctrl_reg;
    localparam int         AW  = 6;
    localparam logic [5:0] RA  = 6'h24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frame_start = 1'b0;
    logic       irq_ack = 1'b0;
    logic       global_ie = 1'b0;
    logic       drv_enable, drv_lowpwr, drv_blank, irq_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference state
    bit m_en, m_wreq, m_breq, m_ie, m_flag, m_wlive, m_blive, m_phase;

    always #4 clk = ~clk;

    lcd_frame_ctrl_reg #(.ADDR_W(AW), .REG_ADDR(RA)) i_lcd_frame_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
        .irq_ack(irq_ack), .global_ie(global_ie), .drv_enable(drv_enable),
        .drv_lowpwr(drv_lowpwr), .drv_blank(drv_blank), .irq_req(irq_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [5:0] a);
        if (a != RA) return 8'h00;
        return {m_en, m_wreq, 1'b0, m_flag, m_ie, 2'b00, m_breq};
    endfunction

    // Advance the model by one rising edge with the inputs now on the pins
    task automatic model_step();
        bit wr, frame, nw, nb, chg, ph, setf, nph, clr;
        wr    = bus_we && (bus_addr == RA);
        frame = m_en && frame_start;
        nw    = wr ? bus_wdata[6] : m_wreq;
        nb    = wr ? bus_wdata[0] : m_breq;
        setf  = 1'b0;
        nph   = m_en ? m_phase : 1'b0;
        if (frame) begin
            chg  = (nw != m_wlive);
            ph   = chg ? 1'b0 : m_phase;
            setf = !nw || !ph;
            nph  = nw ? !ph : 1'b0;
        end
        clr = (wr && bus_wdata[4]) || irq_ack;
        if (setf)     m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        if (!m_en || frame) begin
            m_wlive = nw;
            m_blive = nb;
        end
        m_phase = nph;
        m_wreq  = nw;
        m_breq  = nb;
        if (wr) begin
            m_en = bus_wdata[7];
            m_ie = bus_wdata[3];
        end
    endtask

    task automatic compare_all();
        chk(drv_enable == m_en, "R2 drv_enable", drv_enable, m_en);
        chk(drv_lowpwr == m_wlive, "R4 drv_lowpwr", drv_lowpwr, m_wlive);
        chk(drv_blank == m_blive, "R5 drv_blank", drv_blank, m_blive);
        chk(irq_req == (m_flag && m_ie && global_ie), "R10 irq_req", irq_req,
            m_flag && m_ie && global_ie);
        chk(bus_rdata == exp_rdata(bus_addr), "R3/R13 bus_rdata", bus_rdata,
            exp_rdata(bus_addr));
    endtask

    // One cycle: drive at the falling edge, step the model at the rising edge, compare after it
    task automatic cyc(input bit we, input logic [5:0] a, input logic [7:0] d,
                       input bit fs, input bit ack, input bit gie);
        bus_we = we; bus_addr = a; bus_wdata = d;
        frame_start = fs; irq_ack = ack; global_ie = gie;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, RA, 8'h00, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        bit hold_flag;
        int lp_sets;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(bus_rdata == 8'h00 && !drv_enable && !drv_lowpwr && !drv_blank && !irq_req,
            "R1 reset", {drv_enable, drv_lowpwr, drv_blank, irq_req, bus_rdata}, 0);

        // R3: reserved bits read zero after writing all ones (flag stays clear)
        cyc(1'b1, RA, 8'hFF, 1'b0, 1'b0, 1'b1);
        chk(bus_rdata[5] == 0 && bus_rdata[2] == 0 && bus_rdata[1] == 0, "R3 reserved",
            bus_rdata, exp_rdata(RA));
        cyc(1'b1, RA, 8'h00, 1'b0, 1'b0, 1'b1);

        // R13: write elsewhere ignored, read elsewhere zero
        cyc(1'b1, 6'h11, 8'hC9, 1'b0, 1'b0, 1'b1);
        chk(!drv_enable && bus_rdata == 8'h00, "R13 other address", bus_rdata, 0);

        // R12: strobes while disabled never set the flag
        cyc(1'b0, RA, 8'h00, 1'b1, 1'b0, 1'b1);
        chk(bus_rdata[4] == 1'b0, "R12 disabled strobe", bus_rdata[4], 0);

        // R2 / R6 / R10: enable with interrupt enable, then a frame sets the flag
        cyc(1'b1, RA, 8'h88, 1'b0, 1'b0, 1'b1);
        chk(drv_enable == 1'b1, "R2 enable", drv_enable, 1);
        cyc(1'b0, RA, 8'h00, 1'b1, 1'b0, 1'b1);
        chk(bus_rdata[4] && irq_req, "R6 flag set", {bus_rdata[4], irq_req}, 3);
        cyc(1'b0, RA, 8'h00, 1'b0, 1'b0, 1'b0);
        chk(!irq_req, "R10 global gate", irq_req, 0);

        // R7: write zero to flag keeps it, write one clears
        cyc(1'b1, RA, 8'h88, 1'b0, 1'b0, 1'b1);
        chk(bus_rdata[4] == 1'b1, "R7 write-zero keeps", bus_rdata[4], 1);
        cyc(1'b1, RA, 8'h98, 1'b0, 1'b0, 1'b1);
        chk(bus_rdata[4] == 1'b0, "R7 write-one clears", bus_rdata[4], 0);

        // R8: acknowledge clears
        cyc(1'b0, RA, 8'h00, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, RA, 8'h00, 1'b0, 1'b1, 1'b1);
        chk(bus_rdata[4] == 1'b0, "R8 ack clears", bus_rdata[4], 0);

        // R9: set and clear in the same cycle, set wins
        cyc(1'b1, RA, 8'h98, 1'b1, 1'b1, 1'b1);
        chk(bus_rdata[4] == 1'b1, "R9 set wins", bus_rdata[4], 1);

        // R4 / R5: waveform and blanking deferred while enabled
        cyc(1'b1, RA, 8'hD9, 1'b0, 1'b0, 1'b1);
        chk(!drv_lowpwr && !drv_blank && bus_rdata[6] && bus_rdata[0], "R4 deferred",
            {drv_lowpwr, drv_blank}, 0);
        idle(3);
        chk(!drv_lowpwr && !drv_blank, "R5 held mid-frame", {drv_lowpwr, drv_blank}, 0);

        // R11: entering low power sets the flag, then every second frame
        lp_sets = 0;
        for (int f = 0; f < 6; f++) begin
            cyc(1'b1, RA, 8'hD9, 1'b0, 1'b0, 1'b1);  // clear flag, keep fields
            cyc(1'b0, RA, 8'h00, 1'b1, 1'b0, 1'b1);
            hold_flag = bus_rdata[4];
            chk(hold_flag == ((f % 2) == 0), "R11 decimation", hold_flag, (f % 2) == 0);
            if (hold_flag) lp_sets++;
        end
        chk(drv_lowpwr && drv_blank, "R4 applied at frame", {drv_lowpwr, drv_blank}, 3);
        chk(lp_sets == 3, "R11 set count", lp_sets, 3);

        // R5: clearing blank also waits for a frame
        cyc(1'b1, RA, 8'hC8, 1'b0, 1'b0, 1'b1);
        chk(drv_blank == 1'b1, "R5 clear deferred", drv_blank, 1);
        cyc(1'b0, RA, 8'h00, 1'b1, 1'b0, 1'b1);
        chk(drv_blank == 1'b0, "R5 clear at frame", drv_blank, 0);

        // R2: disable takes effect at once, mid-frame
        cyc(1'b1, RA, 8'h00, 1'b0, 1'b0, 1'b1);
        chk(!drv_enable, "R2 disable at once", drv_enable, 0);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit we, fs, ack, gie;
            logic [5:0] a;
            logic [7:0] d;
            we  = ($urandom % 6) == 0;
            a   = (($urandom % 8) == 0) ? 6'($urandom) : RA;
            d   = 8'($urandom);
            if (($urandom % 4) != 0) d[7] = 1'b1;
            fs  = ($urandom % 5) == 0;
            ack = ($urandom % 12) == 0;
            gie = ($urandom % 4) != 0;
            cyc(we, a, d, fs, ack, gie);
        end
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule